// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This unit collects the interrupt sources of a synchronous serial port that has a transmit FIFO and a receive FIFO, and turns them into one interrupt request. The datapath feeds it the current fill level of each FIFO, a strobe for every completed incoming frame, a strobe for every read from the receive FIFO, and a strobe once per serial bit period. Software reaches the unit through a small register bus with a write port and a separately addressed read port.

There are four sources. Two of them are sticky events: receive overrun and receive time-out. Each is latched when it occurs and stays set until software writes 1 to its bit in the clear register. The other two are live threshold levels: receive FIFO at least half full and transmit FIFO at least half empty. These follow the FIFO levels directly and cannot be cleared. A mask register chooses which sources may drive the interrupt line.

The time-out is tracked by a three-state sequencer:
- `TO_IDLE`: the receive FIFO is empty and the counter is held at zero.
- `TO_COUNT`: the counter advances once per bit strobe.
- `TO_FIRED`: the flag has been raised and counting stops.

The transitions are as follows:
- IDLE→COUNT happens when data is present.
- COUNT→FIRED happens on the last bit period.
- COUNT→IDLE and FIRED→IDLE happen when the FIFO empties.
- FIRED→COUNT happens on a read or a new frame.
- A read or a new frame seen in COUNT keeps the state and returns the counter to zero.

Register map, with the 2-bit address shown in brackets:
- Mask [0]: read/write.
- Raw status [1]: read-only.
- Masked status [2]: read-only.
- Clear [3]: write-only; it reads as 0.

Top module: `serial_irq_status`

## Requirements
- R1: After reset, the mask reads 0, the masked status reads 0 and `irq` is 0. With both FIFO levels at 0, raw status reads 4'b1000.
- R2: Raw bit 0 (overrun) becomes 1 on the clock edge where `frame_done` is high while `rx_level` equals DEPTH. A frame that arrives with a lower level leaves the bit unchanged. Once set, the bit stays set.
- R3: Raw bit 1 (time-out) becomes 1 on the edge that counts the TIMEOUT_BITS-th `bit_tick`. These ticks must fall in `TO_COUNT`, with the receive FIFO non-empty and no restart in between. One tick fewer leaves the bit at 0.
- R4: A `rx_pop` or `frame_done` pulse returns the time-out count to zero. While `rx_level` is 0, ticks are not counted. Counting starts in the cycle after the FIFO becomes non-empty.
- R5: Raw bit 2 equals (`rx_level` >= DEPTH/2) at all times.
- R6: Raw bit 3 equals (`tx_level` <= DEPTH/2) at all times.
- R7: Address 0 holds the 4-bit mask, which is written and read back there. Address 2 reads raw status AND mask.
- R8: In the clear register, writing 1 to bit 0 clears the overrun flag and writing 1 to bit 1 clears the time-out flag. Zero bits, bits 2 and 3, and writes to the read-only addresses change nothing. Address 3 reads as 0.
- R9: If a flag's set event and a write of 1 to its clear bit happen in the same cycle, the flag ends the cycle set.
- R10: `irq` equals the OR of the four masked status bits.
- R11: After a time-out fires, further bit ticks do not raise the flag again until a read, a new frame or an empty FIFO restarts the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | LVLW | Receive FIFO fill level |
| tx_level | input | LVLW | Transmit FIFO fill level |
| frame_done | input | 1 | One-cycle strobe for a completed incoming frame |
| rx_pop | input | 1 | One-cycle strobe for a read from the receive FIFO |
| bit_tick | input | 1 | Strobe once per serial bit period |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 4 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 4 | Register read data, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The threshold bits, masked status, `rd_data` and `irq` are combinational from the current levels and registers. They are therefore due in the same cycle as their inputs. Sticky flags, the mask and the time-out count are each one register deep, so their effect shows just after the edge that captures the strobe or write. Every bench step drives its inputs 2 ns after a rising edge and samples at the same point after the next edge. A result expected on edge k is therefore read after edge k and never before it. The time-out test steps the bench one edge short of the limit and then onto it, which pins the firing edge exactly.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

    localparam logic [1:0] ADDR_MASK   = 2'd0;
    localparam logic [1:0] ADDR_RAW    = 2'd1;
    localparam logic [1:0] ADDR_MASKED = 2'd2;
    localparam logic [1:0] ADDR_CLEAR  = 2'd3;

    localparam int SRC_OVR = 0;
    localparam int SRC_TMO = 1;
    localparam int SRC_RXH = 2;
    localparam int SRC_TXH = 3;
    localparam int NSRC    = 4;
    localparam int NSTICKY = 2;
endpackage

// File: rtl/sirq_sticky_bit.sv
module sirq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && flag_o) |=> flag_o);
endmodule

// File: rtl/sirq_timeout_fsm.sv
module sirq_timeout_fsm
    import sirq_pkg::*;
#(
    parameter int LVLW         = 4,
    parameter int TIMEOUT_BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVLW-1:0] rx_level,
    input  logic            rx_pop,
    input  logic            frame_done,
    input  logic            bit_tick,
    output logic            fire_o
);
    localparam int CNTW = $clog2(TIMEOUT_BITS + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(TIMEOUT_BITS - 1);

    to_state_e       st_q, st_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic            empty, restart, at_last;

    assign empty   = (rx_level == '0);
    assign restart = rx_pop | frame_done;
    assign at_last = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TO_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            TO_IDLE: begin
                cnt_d = '0;
                if (!empty) st_d = TO_COUNT;
            end
            TO_COUNT: begin
                if (empty) begin
                    st_d  = TO_IDLE;
                    cnt_d = '0;
                end else if (restart) begin
                    cnt_d = '0;
                end else if (bit_tick) begin
                    if (at_last) begin
                        st_d  = TO_FIRED;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TO_FIRED: begin
                cnt_d = '0;
                if (empty)        st_d = TO_IDLE;
                else if (restart) st_d = TO_COUNT;
            end
            default: begin
                st_d  = TO_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        fire_o = 1'b0;
        unique case (st_q)
            TO_COUNT: fire_o = !empty && !restart && bit_tick && at_last;
            default:  fire_o = 1'b0;
        endcase
    end

    assert_empty_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> (cnt_q == '0));
    assert_restart_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    assert_fired_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
endmodule

// File: rtl/sirq_regbank.sv
module sirq_regbank
    import sirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [NSRC-1:0]    wr_data,
    input  logic [1:0]         rd_addr,
    input  logic [NSRC-1:0]    raw_i,
    output logic [NSRC-1:0]    mask_o,
    output logic [NSRC-1:0]    masked_o,
    output logic [NSTICKY-1:0] clr_o,
    output logic [NSRC-1:0]    rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_o <= '0;
        else if (wr_en && wr_addr == ADDR_MASK)  mask_o <= wr_data;
    end

    assign masked_o = raw_i & mask_o;
    assign clr_o    = (wr_en && wr_addr == ADDR_CLEAR) ? wr_data[NSTICKY-1:0] : '0;

    always_comb begin
        unique case (rd_addr)
            ADDR_MASK:   rd_data = mask_o;
            ADDR_RAW:    rd_data = raw_i;
            ADDR_MASKED: rd_data = masked_o;
            default:     rd_data = '0;
        endcase
    end

    assert_mask_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_MASK) |=> $stable(mask_o));
    assert_mask_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MASK) |=> (mask_o == $past(wr_data)));
endmodule

// File: rtl/serial_irq_status.sv
module serial_irq_status
    import sirq_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int TIMEOUT_BITS = 32,
    parameter int LVLW         = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVLW-1:0] rx_level,
    input  logic [LVLW-1:0] tx_level,
    input  logic            frame_done,
    input  logic            rx_pop,
    input  logic            bit_tick,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [3:0]      wr_data,
    input  logic [1:0]      rd_addr,
    output logic [3:0]      rd_data,
    output logic            irq
);
    localparam logic [LVLW-1:0] FULL_LVL = LVLW'(DEPTH);
    localparam logic [LVLW-1:0] HALF_LVL = LVLW'(DEPTH / 2);

    logic [NSRC-1:0]    raw, mask, masked;
    logic [NSTICKY-1:0] set_ev, clr_ev, sticky;
    logic               tmo_fire;

    sirq_timeout_fsm #(.LVLW(LVLW), .TIMEOUT_BITS(TIMEOUT_BITS)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_level   (rx_level),
        .rx_pop     (rx_pop),
        .frame_done (frame_done),
        .bit_tick   (bit_tick),
        .fire_o     (tmo_fire)
    );

    assign set_ev[SRC_OVR] = frame_done && (rx_level == FULL_LVL);
    assign set_ev[SRC_TMO] = tmo_fire;

    for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
        sirq_sticky_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_ev[g]),
            .clr_i  (clr_ev[g]),
            .flag_o (sticky[g])
        );
    end

    assign raw[SRC_OVR] = sticky[SRC_OVR];
    assign raw[SRC_TMO] = sticky[SRC_TMO];
    assign raw[SRC_RXH] = (rx_level >= HALF_LVL);
    assign raw[SRC_TXH] = (tx_level <= HALF_LVL);

    sirq_regbank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .raw_i    (raw),
        .mask_o   (mask),
        .masked_o (masked),
        .clr_o    (clr_ev),
        .rd_data  (rd_data)
    );

    assign irq = |masked;

    assert_ovr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_level == FULL_LVL) |=> raw[SRC_OVR]);
    assert_tmo_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> raw[SRC_TMO]);
    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0));
    assert_tmo_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> !tmo_fire);
endmodule

// File: tb/serial_irq_status_tb.sv
module serial_irq_status_tb;
    localparam int DEPTH = 8;
    localparam int TMO   = 32;
    localparam int LVLW  = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n;
    logic [LVLW-1:0] rx_level, tx_level;
    logic            frame_done, rx_pop, bit_tick, wr_en;
    logic [1:0]      wr_addr, rd_addr;
    logic [3:0]      wr_data, rd_data;
    logic            irq;
    int              n_chk = 0;
    int              n_fail = 0;
    bit              done = 1'b0;

    always #4 clk = ~clk;

    serial_irq_status #(.DEPTH(DEPTH), .TIMEOUT_BITS(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .frame_done(frame_done), .rx_pop(rx_pop), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic test_reset();
        logic [3:0] v;
        rd(2'd0, v); check("R1 mask", v, 4'b0000);
        rd(2'd1, v); check("R1 raw", v, 4'b1000);
        rd(2'd2, v); check("R1 masked", v, 4'b0000);
        check("R1 irq", {3'b0, irq}, 4'b0000);
    endtask

    task automatic test_levels();
        logic [3:0] v;
        rx_level = 3; step(); rd(2'd1, v); check("R5 rx=3", {3'b0, v[2]}, 4'd0);
        rx_level = 4; step(); rd(2'd1, v); check("R5 rx=4", {3'b0, v[2]}, 4'd1);
        rx_level = 8; step(); rd(2'd1, v); check("R5 rx=8", {3'b0, v[2]}, 4'd1);
        tx_level = 4; step(); rd(2'd1, v); check("R6 tx=4", {3'b0, v[3]}, 4'd1);
        tx_level = 5; step(); rd(2'd1, v); check("R6 tx=5", {3'b0, v[3]}, 4'd0);
        tx_level = 8; step(); rd(2'd1, v); check("R6 tx=8", {3'b0, v[3]}, 4'd0);
        rx_level = 0; tx_level = 0; step();
    endtask

    task automatic test_overrun();
        logic [3:0] v;
        rx_level = 7; frame_done = 1; step(); frame_done = 0;
        rd(2'd1, v); check("R2 not full", {3'b0, v[0]}, 4'd0);
        rx_level = 8; frame_done = 1; step(); frame_done = 0;
        rd(2'd1, v); check("R2 full", {3'b0, v[0]}, 4'd1);
        step(); rd(2'd1, v); check("R2 sticky", {3'b0, v[0]}, 4'd1);
        wr(2'd3, 4'b0000); rd(2'd1, v); check("R8 zero write", {3'b0, v[0]}, 4'd1);
        wr(2'd3, 4'b0010); rd(2'd1, v); check("R8 other bit", {3'b0, v[0]}, 4'd1);
        wr(2'd1, 4'b1111); rd(2'd1, v); check("R8 raw addr write", {3'b0, v[0]}, 4'd1);
        wr(2'd3, 4'b1100); rd(2'd1, v); check("R8 level bits", v, 4'b1101);
        wr(2'd3, 4'b0001); rd(2'd1, v); check("R8 clear ovr", {3'b0, v[0]}, 4'd0);
        rd(2'd3, v); check("R8 clear reads 0", v, 4'b0000);
        rx_level = 8; frame_done = 1; wr_en = 1; wr_addr = 2'd3; wr_data = 4'b0001;
        step(); frame_done = 0; wr_en = 0; wr_data = 0;
        rd(2'd1, v); check("R9 set wins", {3'b0, v[0]}, 4'd1);
        wr(2'd3, 4'b0001); rx_level = 0; step();
    endtask

    task automatic tick_n(input int n);
        bit_tick = 1;
        for (int i = 0; i < n; i++) step();
        bit_tick = 0;
    endtask

    task automatic test_timeout();
        logic [3:0] v;
        rx_level = 1; tx_level = 8; step();
        tick_n(TMO - 1); rd(2'd1, v); check("R3 one short", {3'b0, v[1]}, 4'd0);
        tick_n(1); rd(2'd1, v); check("R3 fired", {3'b0, v[1]}, 4'd1);
        wr(2'd3, 4'b0010); rd(2'd1, v); check("R8 clear tmo", {3'b0, v[1]}, 4'd0);
        tick_n(TMO + 8); rd(2'd1, v); check("R11 no refire", {3'b0, v[1]}, 4'd0);
        rx_pop = 1; step(); rx_pop = 0;
        tick_n(20);
        frame_done = 1; bit_tick = 1; step(); frame_done = 0; bit_tick = 0;
        tick_n(TMO - 1); rd(2'd1, v); check("R4 frame restart", {3'b0, v[1]}, 4'd0);
        tick_n(1); rd(2'd1, v); check("R4 fires after restart", {3'b0, v[1]}, 4'd1);
        wr(2'd3, 4'b0010);
        rx_level = 0; step();
        tick_n(TMO + 8); rd(2'd1, v); check("R4 empty holds", {3'b0, v[1]}, 4'd0);
        rx_level = 1; step();
        tick_n(TMO); rd(2'd1, v); check("R4 count from refill", {3'b0, v[1]}, 4'd1);
        wr(2'd3, 4'b0010); rx_level = 0; tx_level = 0; step();
    endtask

    task automatic test_mask();
        logic [3:0] v;
        wr(2'd0, 4'b0111); rd(2'd2, v); check("R7 masked off", v, 4'b0000);
        check("R10 irq off", {3'b0, irq}, 4'd0);
        wr(2'd0, 4'b1000); rd(2'd0, v); check("R7 mask readback", v, 4'b1000);
        rd(2'd2, v); check("R7 masked tx", v, 4'b1000);
        check("R10 irq on", {3'b0, irq}, 4'd1);
        tx_level = 8; rx_level = 8; frame_done = 1; step(); frame_done = 0;
        wr(2'd0, 4'b0001); rd(2'd2, v); check("R7 masked ovr", v, 4'b0001);
        check("R10 irq ovr", {3'b0, irq}, 4'd1);
        wr(2'd3, 4'b0001); check("R10 irq cleared", {3'b0, irq}, 4'd0);
        rx_level = 0; tx_level = 0; wr(2'd0, 4'b0000);
    endtask

    initial begin
        rst_n = 0; rx_level = 0; tx_level = 0; frame_done = 0; rx_pop = 0;
        bit_tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        repeat (3) step();
        rst_n = 1; step();
        test_reset();
        test_levels();
        test_overrun();
        test_timeout();
        test_mask();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule